// File: doc/BRIEF.md
# Execution-Phase Byte Transfer Handshake

This block sits between the disk-side byte stream and the host bus while a command is in its execution phase. Every byte the disk side offers (on a read command) or asks for (on a write command) goes into a single holding slot. The host is then asked to service that slot. In DMA mode the request goes out on a request line toward an external DMA controller. In programmed mode the block raises an interrupt for every byte and also shows the request on a polled ready flag.

Each byte has a service window. Its length is a clock-cycle count that depends on the recording density: one count for single density and a shorter one for double density. If the host misses the window, or a further byte turns up while the slot is still occupied, the block flags an overrun and ends the command. A terminal-count input also ends the command. Either way the block stops host transfers, raises the interrupt that opens the result phase, and sends the command sequencer a one-cycle done pulse carrying a cause code.

Top module: `exec_xfer_hs`

## Requirements
- R1: In programmed mode (dma_mode=0), a disk strobe accepted into an empty slot makes irq=1 and rqm=1 from the next clock edge. Both stay high until the byte is serviced.
- R2: In programmed mode the servicing strobe is host_rd for a read command (wr_cmd=0) and host_wr for a write command (wr_cmd=1). It clears irq and rqm at the next edge. The strobe of the other direction has no effect.
- R3: In DMA mode (dma_mode=1), a pending byte drives drq=1, and irq and rqm stay 0 throughout execution.
- R4: drq is 0 in any cycle in which host_dack=1. In DMA mode a byte is serviced only when host_dack=1 and the direction strobe are both high in the same cycle. A strobe without host_dack leaves drq asserted.
- R5: On a read command, host_rdata shows the byte latched from disk_rdata at the accepting edge. On a write command, disk_wdata shows the host_wdata value taken at the servicing edge.
- R6: The service window is FM_CYC cycles when mfm=0 and MFM_CYC cycles when mfm=1, counted from the accepting edge. Service at the window's last edge avoids overrun. If that edge passes with no service, overrun=1 and the command ends at that edge.
- R7: A disk strobe that arrives while the slot is full and is not serviced in the same cycle sets overrun=1 and ends the command at the next edge.
- R8: A disk strobe in the same cycle as the service of the pending byte is accepted as the next byte. No overrun results, and irq stays high in programmed mode.
- R9: tc=1 during execution ends the command at the next edge: drq and rqm drop, and irq=1 marks the result phase. That interrupt clears on a host_rd after execution or on a new start.
- R10: When a command ends, done is high for exactly one cycle and done_cause gives the reason: 2'b01 for terminal count, 2'b10 for overrun. Overrun wins if both occur together. done_cause is 2'b00 whenever done is 0.
- R11: While rst_n is low, drq, irq, rqm, overrun and done are all 0.
- R12: A start pulse clears overrun and begins a fresh execution phase with an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that opens an execution phase |
| dma_mode | input | 1 | 1 = DMA handshake, 0 = interrupt per byte |
| mfm | input | 1 | 1 = double density window, 0 = single density window |
| wr_cmd | input | 1 | 1 = write command (host to disk), 0 = read command |
| disk_stb | input | 1 | Disk side has a byte ready (read) or needs one (write) |
| disk_rdata | input | DW | Byte from the disk side |
| disk_wdata | output | DW | Byte handed to the disk side on write commands |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_dack | input | 1 | DMA acknowledge, active high |
| host_wdata | input | DW | Byte from the host on write commands |
| host_rdata | output | DW | Byte presented to the host on read commands |
| tc | input | 1 | Terminal count |
| drq | output | 1 | DMA request |
| irq | output | 1 | Interrupt, per byte or at end of execution |
| rqm | output | 1 | Polled ready flag that mirrors the per-byte request |
| overrun | output | 1 | Sticky overrun flag, cleared by start |
| done | output | 1 | One-cycle end-of-execution pulse |
| done_cause | output | 2 | End reason, valid with done |

## Verification
Every registered result (irq, rqm, drq from a new byte, overrun, done and its cause, the data registers) becomes visible after exactly one clock edge following the cycle whose inputs cause it. The bench therefore drives inputs on the falling edge and compares on the next falling edge. The one combinational path, host_dack blanking drq, is compared in the same sampling window as the acknowledge it responds to. The service window is timed by idling for exactly one fewer edge than the density count and then either servicing or checking that overrun is still clear, before taking the final edge. This pins both boundaries of the window to the cycle.

// File: rtl/exec_xfer_pkg.sv
package exec_xfer_pkg;

  typedef enum logic [1:0] {
    END_NONE = 2'b00,
    END_TC   = 2'b01,
    END_OVR  = 2'b10
  } end_cause_e;

  // Service window length in cycles for the selected density.
  function automatic int unsigned window_cycles(input logic dbl,
                                                input int unsigned sd_cyc,
                                                input int unsigned dd_cyc);
    return dbl ? dd_cyc : sd_cyc;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xfer_deadline.sv
module xfer_deadline
  import exec_xfer_pkg::*;
#(
  parameter int unsigned FM_CYC  = 27,
  parameter int unsigned MFM_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic waiting,
  input  logic mfm,
  output logic expire
);
  localparam int unsigned MAXC = max_u(FM_CYC, MFM_CYC);
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CW-1:0] age_q;
  logic [CW-1:0] last_age;

  always_comb last_age = CW'(window_cycles(mfm, FM_CYC, MFM_CYC) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (clear || load)  age_q <= '0;
    else if (waiting && age_q != last_age) age_q <= age_q + 1'b1;
  end

  assign expire = waiting && (age_q == last_age);
endmodule

// File: rtl/xfer_slot.sv
module xfer_slot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fill,
  input  logic          take,
  input  logic          wr_dir,
  input  logic [DW-1:0] disk_d,
  input  logic [DW-1:0] host_d,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full <= 1'b0;
    else if (clear)  full <= 1'b0;
    else if (fill)   full <= 1'b1;
    else if (take)   full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 data <= '0;
    else if (!wr_dir && fill)   data <= disk_d;
    else if (wr_dir && take)    data <= host_d;
  end
endmodule

// File: rtl/exec_xfer_hs.sv
module exec_xfer_hs
  import exec_xfer_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned FM_CYC  = 27,
  parameter int unsigned MFM_CYC = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dma_mode,
  input  logic          mfm,
  input  logic          wr_cmd,
  input  logic          disk_stb,
  input  logic [DW-1:0] disk_rdata,
  output logic [DW-1:0] disk_wdata,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_dack,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          tc,
  output logic          drq,
  output logic          irq,
  output logic          rqm,
  output logic          overrun,
  output logic          done,
  output logic [1:0]    done_cause
);
  logic run_q, ovr_q, eirq_q, done_q;
  end_cause_e cause_q;
  logic pend, expire;
  logic [DW-1:0] slot_data;

  // Named events, also used by the bound checker.
  logic dir_stb, svc_evt, collide_evt, late_evt, err_evt, tc_evt, stop_evt, byte_evt;

  always_comb begin
    dir_stb     = wr_cmd ? host_wr : host_rd;
    svc_evt     = run_q && pend && dir_stb && (!dma_mode || host_dack);
    collide_evt = run_q && pend && disk_stb && !svc_evt;
    late_evt    = run_q && expire && !svc_evt;
    err_evt     = collide_evt || late_evt;
    tc_evt      = run_q && tc;
    stop_evt    = err_evt || tc_evt;
    byte_evt    = run_q && disk_stb && (!pend || svc_evt) && !stop_evt && !start;
  end

  xfer_slot #(.DW(DW)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start || stop_evt),
    .fill   (byte_evt),
    .take   (svc_evt),
    .wr_dir (wr_cmd),
    .disk_d (disk_rdata),
    .host_d (host_wdata),
    .full   (pend),
    .data   (slot_data)
  );

  xfer_deadline #(.FM_CYC(FM_CYC), .MFM_CYC(MFM_CYC)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start || stop_evt),
    .load    (byte_evt),
    .waiting (pend),
    .mfm     (mfm),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ovr_q   <= 1'b0;
      eirq_q  <= 1'b0;
      done_q  <= 1'b0;
      cause_q <= END_NONE;
    end else if (start) begin
      run_q   <= 1'b1;
      ovr_q   <= 1'b0;
      eirq_q  <= 1'b0;
      done_q  <= 1'b0;
      cause_q <= END_NONE;
    end else begin
      done_q  <= stop_evt;
      cause_q <= !stop_evt ? END_NONE : (err_evt ? END_OVR : END_TC);
      if (stop_evt) run_q <= 1'b0;
      if (err_evt)  ovr_q <= 1'b1;
      if (stop_evt)                 eirq_q <= 1'b1;
      else if (!run_q && host_rd)   eirq_q <= 1'b0;
    end
  end

  assign drq        = run_q && dma_mode && pend && !host_dack;
  assign rqm        = run_q && !dma_mode && pend;
  assign irq        = eirq_q || rqm;
  assign overrun    = ovr_q;
  assign done       = done_q;
  assign done_cause = cause_q;
  assign host_rdata = slot_data;
  assign disk_wdata = slot_data;
endmodule

// File: rtl/exec_xfer_hs_chk.sv
module exec_xfer_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       dma_mode,
  input logic       disk_stb,
  input logic       tc,
  input logic       pend,
  input logic       run,
  input logic       svc_evt,
  input logic       late_evt,
  input logic       collide_evt,
  input logic       drq,
  input logic       irq,
  input logic       rqm,
  input logic       overrun,
  input logic       done,
  input logic [1:0] done_cause
);
  // R1
  byte_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dma_mode && disk_stb && !pend && !start) |=> irq);

  // R2
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_evt && !disk_stb && !start) |=> (!rqm && !drq));

  // R3
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dma_mode) |-> (!irq && !rqm));

  // R6
  late_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_evt && !start) |=> (overrun && done && done_cause == 2'b10));

  // R7
  collide_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (collide_evt && !start) |=> (overrun && done && !run));

  // R9
  tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tc && !start) |=> (irq && !drq && !rqm && done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done ? (done_cause != 2'b00) : (done_cause == 2'b00));
endmodule

bind exec_xfer_hs exec_xfer_hs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .dma_mode    (dma_mode),
  .disk_stb    (disk_stb),
  .tc          (tc),
  .pend        (pend),
  .run         (run_q),
  .svc_evt     (svc_evt),
  .late_evt    (late_evt),
  .collide_evt (collide_evt),
  .drq         (drq),
  .irq         (irq),
  .rqm         (rqm),
  .overrun     (overrun),
  .done        (done),
  .done_cause  (done_cause)
);

// File: tb/exec_xfer_hs_test.sv
module exec_xfer_hs_test;
  localparam int unsigned DW  = 8;
  localparam int unsigned SDW = 27;
  localparam int unsigned DDW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, dma_mode = 0, mfm = 0, wr_cmd = 0, disk_stb = 0;
  logic host_rd = 0, host_wr = 0, host_dack = 0, tc = 0;
  logic [DW-1:0] disk_rdata = '0, host_wdata = '0;
  logic [DW-1:0] disk_wdata, host_rdata;
  logic drq, irq, rqm, overrun, done;
  logic [1:0] done_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  exec_xfer_hs #(.DW(DW), .FM_CYC(SDW), .MFM_CYC(DDW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode), .mfm(mfm),
    .wr_cmd(wr_cmd), .disk_stb(disk_stb), .disk_rdata(disk_rdata),
    .disk_wdata(disk_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_dack(host_dack), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tc(tc), .drq(drq), .irq(irq), .rqm(rqm), .overrun(overrun),
    .done(done), .done_cause(done_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet;
    start = 0; disk_stb = 0; host_rd = 0; host_wr = 0; host_dack = 0; tc = 0;
  endtask

  task automatic begin_cmd(input logic dm, input logic dd, input logic wd);
    quiet();
    dma_mode = dm; mfm = dd; wr_cmd = wd; start = 1;
    tick();
    start = 0;
  endtask

  // {start,dma,mfm,wr,dstb,rd,wr,dack,tc} data {drq,irq,rqm,ovr,done,cause} byte chk
  localparam int NV = 23;
  localparam logic [32:0] VEC [NV] = '{
    {9'b100000000, 8'h00, 7'b0000000, 8'h00, 1'b0},
    {9'b000010000, 8'hA5, 7'b0110000, 8'hA5, 1'b1},
    {9'b000000000, 8'h00, 7'b0110000, 8'hA5, 1'b1},
    {9'b000001000, 8'h00, 7'b0000000, 8'hA5, 1'b1},
    {9'b000010000, 8'h3C, 7'b0110000, 8'h3C, 1'b1},
    {9'b000000100, 8'h00, 7'b0110000, 8'h3C, 1'b1},
    {9'b000001000, 8'h00, 7'b0000000, 8'h3C, 1'b1},
    {9'b000000001, 8'h00, 7'b0100101, 8'h00, 1'b0},
    {9'b000000000, 8'h00, 7'b0100000, 8'h00, 1'b0},
    {9'b000001000, 8'h00, 7'b0000000, 8'h00, 1'b0},
    {9'b110000000, 8'h00, 7'b0000000, 8'h00, 1'b0},
    {9'b010010000, 8'h5A, 7'b1000000, 8'h5A, 1'b1},
    {9'b010001000, 8'h00, 7'b1000000, 8'h5A, 1'b1},
    {9'b010000010, 8'h00, 7'b0000000, 8'h5A, 1'b1},
    {9'b010000000, 8'h00, 7'b1000000, 8'h5A, 1'b1},
    {9'b010001010, 8'h00, 7'b0000000, 8'h5A, 1'b1},
    {9'b010000000, 8'h00, 7'b0000000, 8'h00, 1'b0},
    {9'b110100000, 8'h00, 7'b0000000, 8'h00, 1'b0},
    {9'b010110000, 8'h00, 7'b1000000, 8'h00, 1'b0},
    {9'b010100110, 8'hC3, 7'b0000000, 8'hC3, 1'b1},
    {9'b010100000, 8'h00, 7'b0000000, 8'hC3, 1'b1},
    {9'b010100001, 8'h00, 7'b0100101, 8'h00, 1'b0},
    {9'b010100000, 8'h00, 7'b0100000, 8'h00, 1'b0}
  };

  task automatic window_case(input logic dd, input int unsigned len, input logic serve_last);
    begin_cmd(1'b0, dd, 1'b0);
    disk_stb = 1; disk_rdata = 8'h99;
    tick();
    disk_stb = 0;
    for (int k = 0; k < int'(len) - 1; k++) tick();
    if (serve_last) begin
      host_rd = 1;
      tick();
      host_rd = 0;
      check("R6 served on last edge: overrun", 32'(overrun), 32'd0);
      check("R6 served on last edge: irq", 32'(irq), 32'd0);
    end else begin
      check("R6 one edge before expiry: overrun", 32'(overrun), 32'd0);
      tick();
      check("R6 missed window: overrun", 32'(overrun), 32'd1);
      check("R6 missed window: done", 32'(done), 32'd1);
      check("R10 missed window: cause", 32'(done_cause), 32'd2);
      check("R6 missed window: end irq, rqm low", 32'({irq, rqm}), 32'b10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 outputs in reset", 32'({drq, irq, rqm, overrun, done}), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // Vector table: R1 R2 R3 R4 R5 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      {start, dma_mode, mfm, wr_cmd, disk_stb, host_rd, host_wr, host_dack, tc} = v[32:24];
      disk_rdata = v[23:16];
      host_wdata = v[23:16];
      tick();
      n_chk++;
      if ({drq, irq, rqm, overrun, done, done_cause} !== v[15:9]) begin
        n_bad++;
        $display("FAIL vector %0d flags (R1 R2 R3 R4 R9 R10): actual %b expected %b",
                 i, {drq, irq, rqm, overrun, done, done_cause}, v[15:9]);
      end
      if (v[0]) begin
        n_chk++;
        if ((wr_cmd ? disk_wdata : host_rdata) !== v[8:1]) begin
          n_bad++;
          $display("FAIL vector %0d data (R5): actual %0h expected %0h",
                   i, (wr_cmd ? disk_wdata : host_rdata), v[8:1]);
        end
      end
    end
    quiet();

    // R6 window boundaries for both densities
    window_case(1'b0, SDW, 1'b1);
    window_case(1'b0, SDW, 1'b0);
    window_case(1'b1, DDW, 1'b1);
    window_case(1'b1, DDW, 1'b0);

    // R7 second byte while slot full
    begin_cmd(1'b0, 1'b0, 1'b0);
    disk_stb = 1; tick();
    tick();
    disk_stb = 0;
    check("R7 collision overrun", 32'(overrun), 32'd1);
    check("R10 collision cause", 32'({done, done_cause}), 32'b110);

    // R12 start clears overrun
    begin_cmd(1'b0, 1'b0, 1'b0);
    check("R12 start clears overrun", 32'(overrun), 32'd0);

    // R10 overrun wins over terminal count
    disk_stb = 1; tick();
    tc = 1; tick();
    disk_stb = 0; tc = 0;
    check("R10 overrun beats tc", 32'({done, done_cause}), 32'b110);

    // R8 new byte in the same cycle as service
    begin_cmd(1'b0, 1'b0, 1'b0);
    disk_stb = 1; disk_rdata = 8'h11; tick();
    disk_rdata = 8'h22; host_rd = 1; tick();
    disk_stb = 0; host_rd = 0;
    check("R8 no overrun on back-to-back", 32'(overrun), 32'd0);
    check("R8 irq stays high", 32'(irq), 32'd1);
    check("R8 second byte held", 32'(host_rdata), 32'h22);

    // R9 terminal count with a pending DMA byte
    begin_cmd(1'b1, 1'b0, 1'b0);
    disk_stb = 1; tick();
    disk_stb = 0;
    check("R3 drq raised", 32'(drq), 32'd1);
    tc = 1; tick();
    tc = 0;
    check("R9 tc drops drq and raises irq", 32'({drq, irq, done, done_cause}), 32'b01101);
    begin_cmd(1'b1, 1'b0, 1'b0);
    check("R9 start clears end irq", 32'(irq), 32'd0);
    quiet();

    summary();
    $finish;
  end
endmodule